// File: doc/BRIEF.md
# Synchronous BCD Up/Down Counter Digit

This block holds one decimal digit in a 4-bit register. It updates that register on the rising clock edge in one of four modes, chosen by a 2-bit select input: parallel load, count up, count down or hold. The load is synchronous, so the value on the data input enters the register only at a clock edge while load mode is selected.

An active-low carry-in enables counting in both directions. An active-low carry-out marks the terminal count of the selected direction. Carry-out is combinational, so a high carry-in forces it high with no clock edge in between. Digits chain by connecting each stage's carry-out to the next stage's carry-in, and all stages share one clock and one select.

The register can hold one of the six non-decimal codes 10 to 15, for example after a load. From any of these codes, counting in either direction returns to the 0 to 9 cycle within two edges, following a fixed successor table. A synchronous active-high reset clears the digit to 0.

Top module: `bcd_digit_counter`

## Requirements
- R1: With select 2'b00 (load), the rising edge copies `load_val` into `count`, whatever the level of `cin_n`.
- R2: With select 2'b01 (up) and `cin_n` low, each edge moves a value 0 to 8 to value+1, and moves 9 to 0.
- R3: With select 2'b10 (down) and `cin_n` low, each edge moves a value 1 to 9 to value-1, and moves 0 to 9.
- R4: With select up or down and `cin_n` high, the edge leaves `count` unchanged.
- R5: With select 2'b11 (hold), the edge leaves `count` unchanged, whatever the level of `cin_n`.
- R6: With `cin_n` low, `cout_n` is low in up mode exactly when `count` is 9, and in down mode exactly when `count` is 0.
- R7: With `cin_n` low, `cout_n` is low in load mode exactly when bits 1 and 2 of `count` are both 0. In hold mode `cout_n` is always high.
- R8: While `cin_n` is high, `cout_n` is high in every mode, combinationally and with no clock edge needed.
- R9: Counting from a code 10 to 15 with `cin_n` low follows this table. Up: 10->11, 11->4, 12->13, 13->4, 14->15, 15->0. Down: 10->9, 11->10, 12->5, 13->12, 14->7, 15->14. Every code therefore reaches 0 to 9 within two edges.
- R10: With `rst` high at a rising edge, `count` becomes 0 at that edge, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | 00 load, 01 up, 10 down, 11 hold |
| cin_n | input | 1 | Count enable and chain input, active low |
| load_val | input | 4 | Value captured in load mode |
| count | output | 4 | Current digit |
| cout_n | output | 1 | Terminal-count flag, active low |

## Verification
A wrong value in the digit register shows on `count` at the next falling edge. When the cascade crosses a digit boundary, the error also reaches the high digit through `cout_n` within one cycle. A bad terminal-count decode shows as the high digit stepping one edge early or late, or never stepping at all. Recovery from codes 10 to 15 is checked one edge at a time, so a wrong successor shows after a single edge.

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       cin_n,
  input  logic [3:0] load_val,
  output logic [3:0] count,
  output logic       cout_n
);

  localparam logic [1:0] M_LOAD = 2'b00;
  localparam logic [1:0] M_UP   = 2'b01;
  localparam logic [1:0] M_DOWN = 2'b10;
  localparam logic [1:0] M_HOLD = 2'b11;

  function automatic logic [3:0] step_up(input logic [3:0] v);
    case (v)
      4'd9:    step_up = 4'd0;
      4'd10:   step_up = 4'd11;
      4'd11:   step_up = 4'd4;
      4'd12:   step_up = 4'd13;
      4'd13:   step_up = 4'd4;
      4'd14:   step_up = 4'd15;
      4'd15:   step_up = 4'd0;
      default: step_up = v + 4'd1;
    endcase
  endfunction

  function automatic logic [3:0] step_down(input logic [3:0] v);
    case (v)
      4'd0:    step_down = 4'd9;
      4'd10:   step_down = 4'd9;
      4'd11:   step_down = 4'd10;
      4'd12:   step_down = 4'd5;
      4'd13:   step_down = 4'd12;
      4'd14:   step_down = 4'd7;
      4'd15:   step_down = 4'd14;
      default: step_down = v - 4'd1;
    endcase
  endfunction

  logic [3:0] nxt;
  logic       term;

  always_comb begin
    nxt = count;
    unique case (mode_sel)
      M_LOAD: nxt = load_val;
      M_UP:   if (!cin_n) nxt = step_up(count);
      M_DOWN: if (!cin_n) nxt = step_down(count);
      M_HOLD: nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) count <= 4'd0;
    else     count <= nxt;
  end

  always_comb begin
    unique case (mode_sel)
      M_LOAD: term = ~count[1] & ~count[2];
      M_UP:   term = (count == 4'd9);
      M_DOWN: term = (count == 4'd0);
      M_HOLD: term = 1'b0;
    endcase
  end

  assign cout_n = ~(term & ~cin_n);

  a_r10_reset_clears: assert property (@(posedge clk) rst |=> count == 4'd0);

  a_r1_load_captures: assert property (@(posedge clk) disable iff (rst)
    mode_sel == M_LOAD |=> count == $past(load_val));

  a_r5_hold_keeps: assert property (@(posedge clk) disable iff (rst)
    mode_sel == M_HOLD |=> $stable(count));

  a_r4_cin_blocks: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == M_UP || mode_sel == M_DOWN) && cin_n |=> $stable(count));

  a_r2_up_wrap: assert property (@(posedge clk) disable iff (rst)
    mode_sel == M_UP && !cin_n && count == 4'd9 |=> count == 4'd0);

  a_r3_down_wrap: assert property (@(posedge clk) disable iff (rst)
    mode_sel == M_DOWN && !cin_n && count == 4'd0 |=> count == 4'd9);

  a_r9_recover_up: assert property (@(posedge clk) disable iff (rst)
    mode_sel == M_UP && !cin_n && count > 4'd9 |=> count != $past(count));

  a_r8_cin_forces_high: assert property (@(posedge clk) disable iff (rst)
    cin_n |-> cout_n);

endmodule

// File: tb/bcd_digit_counter_bench.sv
module bcd_digit_counter_bench;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] sel;
  logic cin_lo;
  logic [3:0] d_lo, d_hi;
  logic [3:0] q_lo, q_hi;
  logic co_lo, co_hi;
  int checks = 0;
  int errors = 0;
  logic [3:0] m_lo, m_hi;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  bcd_digit_counter u_bcd_digit_counter (
    .clk(clk), .rst(rst), .mode_sel(sel), .cin_n(cin_lo),
    .load_val(d_lo), .count(q_lo), .cout_n(co_lo));

  bcd_digit_counter u_bcd_digit_counter_hi (
    .clk(clk), .rst(rst), .mode_sel(sel), .cin_n(co_lo),
    .load_val(d_hi), .count(q_hi), .cout_n(co_hi));

  function automatic logic [3:0] ref_next(logic [3:0] v, logic [1:0] s, logic c);
    if (s == 2'b00) return 4'bx;
    if (s == 2'b11 || c) return v;
    if (s == 2'b01) begin
      case (v)
        9: return 0; 10: return 11; 11: return 4; 12: return 13;
        13: return 4; 14: return 15; 15: return 0;
        default: return v + 1;
      endcase
    end
    case (v)
      0: return 9; 10: return 9; 11: return 10; 12: return 5;
      13: return 12; 14: return 7; 15: return 14;
      default: return v - 1;
    endcase
  endfunction

  function automatic logic ref_cout(logic [3:0] v, logic [1:0] s, logic c);
    if (c) return 1'b1;
    case (s)
      2'b00: return !(v[1] == 0 && v[2] == 0);
      2'b01: return v != 9;
      2'b10: return v != 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string state_tag(logic [3:0] v, logic [1:0] s, logic c);
    if (s == 2'b00) return "R1";
    if (s == 2'b11) return "R5";
    if (c) return "R4";
    if (v > 9) return "R9";
    return (s == 2'b01) ? "R2" : "R3";
  endfunction

  function automatic string cout_tag(logic [1:0] s, logic c);
    if (c) return "R8";
    if (s == 2'b01 || s == 2'b10) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // called at a falling edge: drive, check carries, clock, check state
  task automatic step(logic [1:0] s, logic c, logic [3:0] dl, logic [3:0] dh);
    logic cm_lo;
    string tl, th;
    sel = s; cin_lo = c; d_lo = dl; d_hi = dh;
    #1;
    cm_lo = ref_cout(m_lo, s, c);
    check(cout_tag(s, c), "cout_lo", co_lo, cm_lo);
    check(cout_tag(s, cm_lo), "cout_hi", co_hi, ref_cout(m_hi, s, cm_lo));
    tl = state_tag(m_lo, s, c);
    th = state_tag(m_hi, s, cm_lo);
    m_lo = (s == 2'b00) ? dl : ref_next(m_lo, s, c);
    m_hi = (s == 2'b00) ? dh : ref_next(m_hi, s, cm_lo);
    @(negedge clk);
    check(tl, "q_lo", q_lo, m_lo);
    check(th, "q_hi", q_hi, m_hi);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; sel = 2'b01; cin_lo = 1'b0; d_lo = 0; d_hi = 0;
    @(negedge clk); @(negedge clk);
    check("R10", "q_lo after reset", q_lo, 0);
    check("R10", "q_hi after reset", q_hi, 0);
    rst = 1'b0; m_lo = 0; m_hi = 0;

    // R2 cascade up 00..99 and wrap
    for (int i = 0; i < 101; i++) step(2'b01, 1'b0, 0, 0);
    // R3 cascade down with wrap
    for (int i = 0; i < 101; i++) step(2'b10, 1'b0, 0, 0);
    // load 7 then up through 9 and wrap
    step(2'b00, 1'b1, 7, 2);
    for (int i = 0; i < 4; i++) step(2'b01, 1'b0, 0, 0);
    // load 3 then down to 0 and wrap
    step(2'b00, 1'b0, 3, 5);
    for (int i = 0; i < 4; i++) step(2'b10, 1'b0, 0, 0);
    // R4 and R5: enable high and hold
    step(2'b01, 1'b1, 0, 0); step(2'b10, 1'b1, 0, 0);
    step(2'b11, 1'b0, 0, 0); step(2'b11, 1'b1, 0, 0);
    // R9 recovery from every non-decimal code, both directions, two edges
    for (int v = 10; v < 16; v++) begin
      step(2'b00, 1'b0, 4'(v), 4'(v));
      step(2'b01, 1'b0, 0, 0); step(2'b01, 1'b0, 0, 0);
      check("R9", "legal after two up", int'(q_lo < 10), 1);
      step(2'b00, 1'b0, 4'(v), 4'(v));
      step(2'b10, 1'b0, 0, 0); step(2'b10, 1'b0, 0, 0);
      check("R9", "legal after two down", int'(q_lo < 10), 1);
    end
    // R7 load mode carry decode
    for (int v = 0; v < 16; v++) begin
      step(2'b00, 1'b0, 4'(v), 4'(15 - v));
      step(2'b00, 1'b0, 4'(v), 4'(v));
    end
    // random mix, loads mostly rare
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 19);
      logic [1:0] s = (r == 0) ? 2'b00 : (r < 9) ? 2'b01 : (r < 16) ? 2'b10 : 2'b11;
      step(s, ($urandom_range(0, 4) == 0), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
    end
    // R10 reset from a non-zero state in hold mode
    step(2'b00, 1'b0, 6, 8);
    sel = 2'b11; rst = 1'b1;
    @(negedge clk);
    check("R10", "q_lo reset in hold", q_lo, 0);
    check("R10", "q_hi reset in hold", q_hi, 0);
    rst = 1'b0;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule